// File: doc/BRIEF.md
# Power-Good Output Generator

This block reduces the comparator results of several supply rails to a single power-good indication and presents it on a pin model. Each rail supplies an undervoltage flag, an overvoltage flag, a monitor-enable bit and a latched fault flag. An 8-bit configuration byte sets how the rails are judged, how long the good state must hold before it is reported, and how the pin is driven.

The rise to "good" is debounced by a counter with a short or a long limit. The fall to "not good" bypasses the counter and reaches the pin one clock later. The pin is modelled as a data value plus a drive enable, so push-pull and open-drain stages can both be represented.

The block also produces an active-low interrupt pin value. This value normally passes the incoming request through unchanged. Optionally, it is also pulled low whenever rail 0 is not good.

Top module: `pgood_out_gen`

## Requirements
- R1: Configuration bit 2 selects how a rail is judged. When it is 0, an enabled rail is good when its undervoltage flag is 0. When it is 1, the rail is good only when both its undervoltage and overvoltage flags are 0.
- R2: A rail whose monitor-enable bit is 0 does not affect the combined status. With no rail enabled, the combined status is good.
- R3: The internal good state asserts on the Nth consecutive clock edge at which the combined status is good. N is SHORT_CNT when configuration bit 5 is 0 and LONG_CNT when it is 1.
- R4: A not-good combined status clears the internal good state at the next clock edge. Any not-good cycle during the count restarts the count from zero.
- R5: When configuration bit 4 is 1, the combined status comes from the latched fault flags instead of the comparators. The status is not good if any enabled rail has its fault flag at 1.
- R6: Configuration bit 0 sets the polarity. With 0, the pin level is 1 when the state is good. With 1, the pin level is 0 when the state is good.
- R7: Configuration bit 1 sets the drive type. With 0 (push-pull), pg_oe_o is 1 and pg_pin_o carries the level. With 1 (open-drain), pg_pin_o is 0 and pg_oe_o is 1 exactly when the level is 0.
- R8: When configuration bit 6 is 1, int_n_o is low if irq_n_i is low or rail 0 is not good. Rail 0 is judged live, per R1, regardless of its enable bit. When bit 6 is 0, int_n_o equals irq_n_i.
- R9: Configuration bits 3 and 7 have no effect on any output.
- R10: During and after reset, the good state is 0 and the count is zero. The pin therefore shows the inactive level for the current polarity and drive type.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| uv_i | input | NUM_RAILS | Per-rail undervoltage flags |
| ov_i | input | NUM_RAILS | Per-rail overvoltage flags |
| mon_en_i | input | NUM_RAILS | Per-rail monitor enable |
| flt_i | input | NUM_RAILS | Per-rail latched fault flags, 1 = fault |
| irq_n_i | input | 1 | Incoming active-low interrupt request |
| cfg_i | input | 8 | Configuration byte |
| pg_pin_o | output | 1 | Power-good pin data value |
| pg_oe_o | output | 1 | Power-good pin drive enable |
| int_n_o | output | 1 | Combined active-low interrupt pin value |

## Verification
The bench builds the block with four rails, SHORT_CNT of 8 and LONG_CNT of 40. With these values, the last non-good cycle and the first good cycle of both debounce limits can be checked exactly within a few hundred clocks. The default long limit corresponds to milliseconds of clock time and is left out of the bench. Four rails are enough for one rail to be masked, faulted or over-voltage while the others stay good, which brings the mask, window and latched-fault cases within reach.

// File: rtl/pg_pkg.sv
package pg_pkg;
   // configuration byte field positions
   localparam int unsigned CFG_W     = 8;
   localparam int unsigned BIT_POL   = 0;
   localparam int unsigned BIT_OD    = 1;
   localparam int unsigned BIT_WIN   = 2;
   localparam int unsigned BIT_LATCH = 4;
   localparam int unsigned BIT_LONG  = 5;
   localparam int unsigned BIT_MERGE = 6;
endpackage

// File: rtl/pg_rail_eval.sv
module pg_rail_eval #(
   parameter int unsigned NUM_RAILS = 4
) (
   input  logic [NUM_RAILS-1:0] uv_i,
   input  logic [NUM_RAILS-1:0] ov_i,
   input  logic [NUM_RAILS-1:0] mon_en_i,
   input  logic [NUM_RAILS-1:0] flt_i,
   input  logic                 window_i,
   input  logic                 latched_i,
   output logic                 raw_ok_o,
   output logic                 rail0_ok_o
);
   logic [NUM_RAILS-1:0] live_ok;
   logic [NUM_RAILS-1:0] lat_ok;

   for (genvar g = 0; g < NUM_RAILS; g++) begin : g_rail
      assign live_ok[g] = ~mon_en_i[g] | (~uv_i[g] & (~window_i | ~ov_i[g]));
      assign lat_ok[g]  = ~mon_en_i[g] | ~flt_i[g];
   end

   assign raw_ok_o   = latched_i ? (&lat_ok) : (&live_ok);
   assign rail0_ok_o = ~uv_i[0] & (~window_i | ~ov_i[0]);
endmodule

// File: rtl/pg_debounce.sv
module pg_debounce #(
   parameter int unsigned SHORT_CNT = 600,
   parameter int unsigned LONG_CNT  = 1100000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ok_i,
   input  logic long_i,
   output logic valid_o
);
   localparam int unsigned CW = $clog2(LONG_CNT + 1);
   localparam logic [CW-1:0] SHORT_LIM = CW'(SHORT_CNT - 1);
   localparam logic [CW-1:0] LONG_LIM  = CW'(LONG_CNT - 1);

   if (SHORT_CNT < 1 || LONG_CNT < SHORT_CNT) begin : g_bad_cnt
      $error("pg_debounce: need 1 <= SHORT_CNT <= LONG_CNT");
   end

   logic [CW-1:0] cnt;
   logic [CW-1:0] lim;

   assign lim = long_i ? LONG_LIM : SHORT_LIM;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         valid_o <= 1'b0;
      end else if (!ok_i) begin
         cnt     <= '0;
         valid_o <= 1'b0;
      end else if (!valid_o) begin
         if (cnt >= lim) begin
            cnt     <= '0;
            valid_o <= 1'b1;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/pg_pin_drive.sv
module pg_pin_drive (
   input  logic valid_i,
   input  logic inv_pol_i,
   input  logic open_drain_i,
   input  logic irq_n_i,
   input  logic merge_i,
   input  logic rail0_ok_i,
   output logic pin_o,
   output logic oe_o,
   output logic int_n_o
);
   logic level;

   assign level   = valid_i ^ inv_pol_i;
   assign pin_o   = open_drain_i ? 1'b0 : level;
   assign oe_o    = open_drain_i ? ~level : 1'b1;
   assign int_n_o = irq_n_i & (~merge_i | rail0_ok_i);
endmodule

// File: rtl/pgood_out_gen.sv
module pgood_out_gen
   import pg_pkg::*;
#(
   parameter int unsigned NUM_RAILS = 4,
   parameter int unsigned SHORT_CNT = 600,
   parameter int unsigned LONG_CNT  = 1100000
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_RAILS-1:0] uv_i,
   input  logic [NUM_RAILS-1:0] ov_i,
   input  logic [NUM_RAILS-1:0] mon_en_i,
   input  logic [NUM_RAILS-1:0] flt_i,
   input  logic                 irq_n_i,
   input  logic [CFG_W-1:0]     cfg_i,
   output logic                 pg_pin_o,
   output logic                 pg_oe_o,
   output logic                 int_n_o
);
   if (NUM_RAILS < 1) begin : g_bad_rails
      $error("pgood_out_gen: NUM_RAILS must be at least 1");
   end

   logic inv_pol, open_drain, window, latched, long_dly, merge;
   logic raw_ok, rail0_ok, pg_valid;
   logic unused_cfg;

   assign inv_pol    = cfg_i[BIT_POL];
   assign open_drain = cfg_i[BIT_OD];
   assign window     = cfg_i[BIT_WIN];
   assign latched    = cfg_i[BIT_LATCH];
   assign long_dly   = cfg_i[BIT_LONG];
   assign merge      = cfg_i[BIT_MERGE];
   assign unused_cfg = ^{cfg_i[7], cfg_i[3]};

   pg_rail_eval #(.NUM_RAILS(NUM_RAILS)) u_eval (
      .uv_i       (uv_i),
      .ov_i       (ov_i),
      .mon_en_i   (mon_en_i),
      .flt_i      (flt_i),
      .window_i   (window),
      .latched_i  (latched),
      .raw_ok_o   (raw_ok),
      .rail0_ok_o (rail0_ok)
   );

   pg_debounce #(.SHORT_CNT(SHORT_CNT), .LONG_CNT(LONG_CNT)) u_deb (
      .clk     (clk),
      .rst_n   (rst_n),
      .ok_i    (raw_ok),
      .long_i  (long_dly),
      .valid_o (pg_valid)
   );

   pg_pin_drive u_drv (
      .valid_i      (pg_valid),
      .inv_pol_i    (inv_pol),
      .open_drain_i (open_drain),
      .irq_n_i      (irq_n_i),
      .merge_i      (merge),
      .rail0_ok_i   (rail0_ok),
      .pin_o        (pg_pin_o),
      .oe_o         (pg_oe_o),
      .int_n_o      (int_n_o)
   );
endmodule

// File: rtl/pgood_out_gen_chk.sv
module pgood_out_gen_chk #(
   parameter int unsigned SHORT_CNT = 600
) (
   input logic clk,
   input logic rst_n,
   input logic raw_ok,
   input logic pg_valid,
   input logic rail0_ok,
   input logic inv_pol,
   input logic open_drain,
   input logic merge,
   input logic irq_n_i,
   input logic pg_pin_o,
   input logic pg_oe_o,
   input logic int_n_o
);
   logic [31:0] run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                run <= '0;
      else if (!raw_ok)          run <= '0;
      else if (run != 32'hFFFF_FFFF) run <= run + 1;
   end

   AST_DROP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      !raw_ok |=> !pg_valid);                                   // R4
   AST_RISE_DEBOUNCED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pg_valid) |-> run >= SHORT_CNT);                     // R3
   AST_OD_NEVER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      open_drain |-> (!pg_oe_o || !pg_pin_o));                   // R7
   AST_PP_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      !open_drain |-> (pg_oe_o && (pg_pin_o == (pg_valid ^ inv_pol)))); // R6
   AST_INT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      !merge |-> (int_n_o == irq_n_i));                          // R8
   AST_INT_RAIL0: assert property (@(posedge clk) disable iff (!rst_n)
      (merge && !rail0_ok) |-> !int_n_o);                        // R8
   AST_RESET_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !pg_valid);                               // R10
endmodule

bind pgood_out_gen pgood_out_gen_chk #(.SHORT_CNT(SHORT_CNT)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .raw_ok     (raw_ok),
   .pg_valid   (pg_valid),
   .rail0_ok   (rail0_ok),
   .inv_pol    (inv_pol),
   .open_drain (open_drain),
   .merge      (merge),
   .irq_n_i    (irq_n_i),
   .pg_pin_o   (pg_pin_o),
   .pg_oe_o    (pg_oe_o),
   .int_n_o    (int_n_o)
);

// File: tb/tb_pgood_out_gen.sv
`timescale 1ns/1ps
module tb_pgood_out_gen;
   localparam int unsigned NR    = 4;
   localparam int unsigned SHORT = 8;
   localparam int unsigned LONG  = 40;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NR-1:0] uv = '1, ov = '0, en = '1, flt = '0;
   logic          irq_n = 1'b1;
   logic [7:0]    cfg = 8'h00;
   logic          pin, oe, int_n;
   int            n_chk = 0, n_err = 0;

   always #5 clk = ~clk;

   pgood_out_gen #(.NUM_RAILS(NR), .SHORT_CNT(SHORT), .LONG_CNT(LONG)) dut (
      .clk(clk), .rst_n(rst_n), .uv_i(uv), .ov_i(ov), .mon_en_i(en), .flt_i(flt),
      .irq_n_i(irq_n), .cfg_i(cfg), .pg_pin_o(pin), .pg_oe_o(oe), .int_n_o(int_n));

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // all rails bad for a few cycles so the count is cleared
   task automatic go_bad();
      @(negedge clk);
      uv = '1; ov = '0; en = '1; flt = '0;
      @(negedge clk); @(negedge clk);
   endtask

   // called right after inputs are set at a negedge; push-pull, polarity 0
   task automatic wait_valid(input int lim, input string req);
      repeat (lim - 1) @(negedge clk);
      chk({req, " still low before limit"}, pin, 0);
      @(negedge clk);
      chk({req, " high at limit"}, pin, 1);
   endtask

   task automatic t_reset();      // R10
      uv = '0;
      cfg = 8'h00; #1 chk("R10 pp pol0 pin", pin, 0); chk("R10 pp oe", oe, 1);
      cfg = 8'h01; #1 chk("R10 pp pol1 pin", pin, 1);
      cfg = 8'h02; #1 chk("R10 od pol0 oe", oe, 1); chk("R10 od pin", pin, 0);
      cfg = 8'h03; #1 chk("R10 od pol1 oe", oe, 0);
      cfg = 8'h00;
      @(negedge clk); rst_n = 1'b1;
      wait_valid(SHORT, "R10");
   endtask

   task automatic t_window();     // R1
      cfg = 8'h00; go_bad();
      uv = '0; ov = 4'b0100;
      wait_valid(SHORT, "R1 uv-only");
      cfg = 8'h04; @(negedge clk);
      chk("R1 window ov bad", pin, 0);
      ov = '0;
      wait_valid(SHORT, "R1 window ok");
      cfg = 8'h00;
   endtask

   task automatic t_mask();       // R2
      go_bad();
      en = '0;
      wait_valid(SHORT, "R2 none enabled");
      en = 4'b0001; @(negedge clk);
      chk("R2 rail0 enabled bad", pin, 0);
      uv = 4'b1110;
      wait_valid(SHORT, "R2 masked rails ignored");
   endtask

   task automatic t_long();       // R3
      cfg = 8'h20; go_bad();
      uv = '0;
      wait_valid(LONG, "R3 long");
      cfg = 8'h00; go_bad();
      uv = '0;
      wait_valid(SHORT, "R3 short");
   endtask

   task automatic t_restart();    // R4
      go_bad();
      uv = '0;
      repeat (5) @(negedge clk);
      uv[1] = 1'b1; @(negedge clk);
      chk("R4 glitch keeps low", pin, 0);
      uv = '0;
      wait_valid(SHORT, "R4 restart");
      uv[3] = 1'b1; @(negedge clk);
      chk("R4 drop next cycle", pin, 0);
   endtask

   task automatic t_latched();    // R5
      cfg = 8'h00; go_bad();
      cfg = 8'h10; uv = '1; flt = '0;
      wait_valid(SHORT, "R5 no faults");
      flt = 4'b0010; @(negedge clk);
      chk("R5 fault drops", pin, 0);
      en = 4'b1101;
      wait_valid(SHORT, "R5 masked fault");
      cfg = 8'h00;
   endtask

   task automatic t_pins();       // R6 R7
      cfg = 8'h00; go_bad();
      uv = '0;
      wait_valid(SHORT, "R6 setup");
      cfg = 8'h01; #1 chk("R6 good pol1 pin", pin, 0); chk("R6 good pol1 oe", oe, 1);
      cfg = 8'h02; #1 chk("R7 good od oe", oe, 0); chk("R7 good od pin", pin, 0);
      cfg = 8'h03; #1 chk("R7 good od pol1 oe", oe, 1);
      cfg = 8'h00; @(negedge clk);
      uv = '1; @(negedge clk);
      chk("R6 bad pol0 pin", pin, 0);
      cfg = 8'h02; #1 chk("R7 bad od oe", oe, 1); chk("R7 bad od pin", pin, 0);
      cfg = 8'h03; #1 chk("R7 bad od pol1 oe", oe, 0);
      cfg = 8'h01; #1 chk("R6 bad pol1 pin", pin, 1); chk("R6 bad pol1 oe", oe, 1);
      cfg = 8'h00;
   endtask

   task automatic t_merge();      // R8
      @(negedge clk);
      cfg = 8'h40; irq_n = 1'b1; uv = '0; ov = '0;
      #1 chk("R8 merge all good", int_n, 1);
      uv[0] = 1'b1; #1 chk("R8 merge rail0 bad", int_n, 0);
      en = 4'b1110; #1 chk("R8 rail0 masked still merges", int_n, 0);
      en = '1; uv = '0; irq_n = 1'b0; #1 chk("R8 merge irq low", int_n, 0);
      cfg = 8'h44; irq_n = 1'b1; ov[0] = 1'b1; #1 chk("R8 window ov rail0", int_n, 0);
      cfg = 8'h00; uv[0] = 1'b1; #1 chk("R8 no merge passes irq", int_n, 1);
      irq_n = 1'b0; #1 chk("R8 no merge irq low", int_n, 0);
      irq_n = 1'b1; ov = '0;
   endtask

   task automatic t_reserved();   // R9
      cfg = 8'h88; go_bad();
      uv = '0;
      wait_valid(SHORT, "R9 bits 3,7 timing");
      #1 chk("R9 oe", oe, 1);
      irq_n = 1'b0; #1 chk("R9 int", int_n, 0);
      irq_n = 1'b1; cfg = 8'h00;
   endtask

   initial begin
      #(200000 * 10);
      n_chk++; n_err++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      #2;
      t_reset();
      t_window();
      t_mask();
      t_long();
      t_restart();
      t_latched();
      t_pins();
      t_merge();
      t_reserved();
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule